// File: doc/BRIEF.md
# Two-Bank Synchronous Graphics DRAM Read Scheduler

This block sits between a simple read-request source and the command and address pins of a two-bank synchronous graphics DRAM. Each request names a bank, a row, a column and an auto-precharge flag. A request may instead ask for both banks to be closed together. For each bank the block keeps its open row, its state and its timing counters. It emits one command per cycle (activate, read, precharge, or no-operation) at the earliest cycle that every timing rule allows. A row miss is handled by closing the bank and opening the new row before the read.

Read data comes back on the DRAM data pins a fixed CAS latency after each read command, as a burst of BL words. A shift line carries a tag for each read so that exactly those words are captured and handed out with a valid strobe. The two banks are independent. While one bank is still streaming its burst or closing itself, the other bank can be opened and read, so back-to-back reads to alternate banks keep the data bus full.

Top module: `sgram_bank_sched`

## Requirements
- R1: During and right after reset, `cmd_o` is NOP (code 0), `rd_valid_o` is low and `req_ready` is low.
- R2: `cmd_o` codes are NOP=0, ACT=1, READ=2, PRE=3. `addr_o[10]` selects the bank on ACT, READ and PRE. ACT carries the row on `addr_o[9:0]`. READ carries the column on `addr_o[7:0]`, with `addr_o[9]`=1 meaning auto-precharge. PRE with `addr_o[9]`=1 closes both banks.
- R3: Two ACT commands are never closer than T_RRD cycles.
- R4: A READ to a bank comes at least T_RCD cycles after that bank's ACT. For a request to a closed bank the READ comes exactly T_RCD cycles after the ACT.
- R5: For a READ on the bus in cycle t, burst word k is taken from `dq_i` in cycle t+CL+k and shown on `rd_data_o` with `rd_valid_o` high in cycle t+CL+1+k. Exactly BL valid words are produced per READ, in request order.
- R6: An ACT to a bank comes at least T_RP cycles after that bank was precharged. On a row miss with no other limit active, it comes exactly T_RP cycles after the PRE.
- R7: On a row miss the order is PRE, then ACT of the new row, then READ. The PRE comes no earlier than T_RAS cycles after the bank's ACT, and no earlier than CL+BL-2 cycles after the bank's last READ.
- R8: A READ with auto-precharge starts the bank's internal precharge CL+BL-2 cycles after the READ, or later if T_RAS has not yet expired. No command touches that bank until T_RP after that start, and a pending ACT to it is issued exactly then.
- R9: A request with `req_pall`=1 issues a PRE with `addr_o[9]`=1 that closes both banks. It is not issued while either bank is locked, and the next ACT waits T_RP cycles.
- R10: READs to two different open banks in consecutive requests are spaced exactly BL cycles apart, so `rd_valid_o` stays high for 2*BL cycles in a row.
- R11: `req_ready` is high in the cycle the request's final command (READ, or the both-bank PRE) is chosen. That command appears on `cmd_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_pall | input | 1 | Request closes both banks instead of reading |
| req_bank | input | 1 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Burst start column |
| req_ap | input | 1 | Close the bank automatically after this read |
| req_ready | output | 1 | Request completes at this clock edge |
| cmd_o | output | 2 | DRAM command code |
| addr_o | output | ROW_W+1 | DRAM address / bank / flag bits |
| dq_i | input | DQ_W | DRAM read data |
| rd_data_o | output | DQ_W | Captured burst word |
| rd_valid_o | output | 1 | `rd_data_o` holds a burst word |

## Verification
The assertions assume that every timing parameter is at least one cycle and fits in eight bits. They also assume that a request's fields stay unchanged while `req_valid` is high and `req_ready` is low. Their auto-precharge lockout window is the shortest one the rules allow, so a later internal start caused by T_RAS never trips them. The bench keeps each request steady until it sees `req_ready`. It uses row and column values within their widths, and its SGRAM model answers only with data drawn from the rows and columns seen on the command bus.

// File: rtl/sgram_sched_pkg.sv
package sgram_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_READ = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_APWAIT = 2'd2,
        BK_PRECH  = 2'd3
    } bank_st_e;

    typedef struct packed {
        bank_st_e st;
        logic     rcd_ok;
        logic     ras_ok;
        logic     rdp_ok;
        logic     closed_ok;
    } bank_view_t;

    function automatic int unsigned cnt_w(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/sgram_bank_fsm.sv
module sgram_bank_fsm
    import sgram_sched_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int CL    = 3,
    parameter int BL    = 4,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             rd_i,
    input  logic             ap_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output bank_view_t       view_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int RDP    = CL + BL - 2;
    localparam int RDP_LD = (RDP > 0) ? RDP - 1 : 0;
    localparam int RCD_W  = cnt_w(T_RCD);
    localparam int RP_W   = cnt_w(T_RP);
    localparam int RAS_W  = cnt_w(T_RAS);
    localparam int RDP_W  = cnt_w(RDP);

    bank_st_e         st_q;
    logic [RCD_W-1:0] rcd_q;
    logic [RP_W-1:0]  rp_q;
    logic [RAS_W-1:0] ras_q;
    logic [RDP_W-1:0] rdp_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            rcd_q <= '0;
            rp_q  <= '0;
            ras_q <= '0;
            rdp_q <= '0;
            row_q <= '0;
        end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
            if (ras_q != '0) ras_q <= ras_q - 1'b1;
            if (rdp_q != '0) rdp_q <= rdp_q - 1'b1;
            if (act_i) begin
                st_q  <= BK_ACTIVE;
                row_q <= row_i;
                rcd_q <= RCD_W'(T_RCD - 1);
                ras_q <= RAS_W'(T_RAS - 1);
            end else if (rd_i) begin
                rdp_q <= RDP_W'(RDP_LD);
                if (ap_i) st_q <= BK_APWAIT;
            end else if (pre_i) begin
                st_q <= BK_PRECH;
                rp_q <= RP_W'(T_RP - 1);
            end else if (st_q == BK_APWAIT && rdp_q == '0 && ras_q == '0) begin
                st_q <= BK_PRECH;
                rp_q <= RP_W'(T_RP - 1);
            end else if (st_q == BK_PRECH && rp_q == '0) begin
                st_q <= BK_IDLE;
            end
        end
    end

    always_comb begin
        view_o.st        = st_q;
        view_o.rcd_ok    = (rcd_q == '0);
        view_o.ras_ok    = (ras_q == '0);
        view_o.rdp_ok    = (rdp_q == '0);
        view_o.closed_ok = (st_q == BK_IDLE) || (st_q == BK_PRECH && rp_q == '0);
    end

    assign row_o = row_q;

endmodule

// File: rtl/sgram_rd_capture.sv
module sgram_rd_capture
    import sgram_sched_pkg::*;
#(
    parameter int CL   = 3,
    parameter int BL   = 4,
    parameter int DQ_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire_i,
    input  logic [DQ_W-1:0] dq_i,
    output logic [DQ_W-1:0] data_o,
    output logic            valid_o
);
    localparam int BC_W = cnt_w(BL);

    logic [CL-1:0]   tag_q;
    logic [BC_W-1:0] left_q;
    logic            win;

    assign win = tag_q[CL-1] || (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q   <= '0;
            left_q  <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            tag_q <= (tag_q << 1) | CL'(fire_i);
            if (tag_q[CL-1])       left_q <= BC_W'(BL - 1);
            else if (left_q != '0) left_q <= left_q - 1'b1;
            valid_o <= win;
            if (win) data_o <= dq_i;
        end
    end

endmodule

// File: rtl/sgram_bank_sched.sv
module sgram_bank_sched
    import sgram_sched_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 8,
    parameter int DQ_W  = 32,
    parameter int CL    = 3,
    parameter int BL    = 4,
    parameter int T_RRD = 2,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_pall,
    input  logic               req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [COL_W-1:0]   req_col,
    input  logic               req_ap,
    output logic               req_ready,
    output logic [1:0]         cmd_o,
    output logic [ROW_W:0]     addr_o,
    input  logic [DQ_W-1:0]    dq_i,
    output logic [DQ_W-1:0]    rd_data_o,
    output logic               rd_valid_o
);
    localparam int NBANK  = 2;
    localparam int ADDR_W = ROW_W + 1;
    localparam int RRD_W  = cnt_w(T_RRD);
    localparam int CCD_W  = cnt_w(BL);

    bank_view_t       view [NBANK];
    logic [ROW_W-1:0] brow [NBANK];
    logic [NBANK-1:0] act_v, rd_v, pre_v;

    cmd_e             nxt_cmd, cmd_q;
    logic [ADDR_W-1:0] nxt_addr, addr_q;
    logic [RRD_W-1:0] rrd_q;
    logic [CCD_W-1:0] ccd_q;
    logic             pall_ok;
    bank_view_t       sel;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sgram_bank_fsm #(
            .ROW_W(ROW_W), .CL(CL), .BL(BL),
            .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
        ) bank_i (
            .clk(clk), .rst(rst),
            .act_i(act_v[g]), .rd_i(rd_v[g]), .ap_i(req_ap), .pre_i(pre_v[g]),
            .row_i(req_row), .view_o(view[g]), .row_o(brow[g])
        );
    end

    assign sel = view[req_bank];

    always_comb begin
        pall_ok = 1'b1;
        for (int i = 0; i < NBANK; i++) begin
            if (!(view[i].closed_ok ||
                  (view[i].st == BK_ACTIVE && view[i].ras_ok && view[i].rdp_ok)))
                pall_ok = 1'b0;
        end
    end

    always_comb begin
        nxt_cmd   = CMD_NOP;
        nxt_addr  = '0;
        req_ready = 1'b0;
        act_v     = '0;
        rd_v      = '0;
        pre_v     = '0;
        if (req_valid) begin
            if (req_pall) begin
                if (pall_ok) begin
                    nxt_cmd   = CMD_PRE;
                    nxt_addr  = {1'b0, 1'b1, (ROW_W-1)'(0)};
                    pre_v     = '1;
                    req_ready = 1'b1;
                end
            end else begin
                case (sel.st)
                    BK_ACTIVE: begin
                        if (brow[req_bank] == req_row) begin
                            if (sel.rcd_ok && ccd_q == '0) begin
                                nxt_cmd          = CMD_READ;
                                nxt_addr         = {req_bank, req_ap, (ROW_W-1)'(req_col)};
                                rd_v[req_bank]   = 1'b1;
                                req_ready        = 1'b1;
                            end
                        end else if (sel.ras_ok && sel.rdp_ok) begin
                            nxt_cmd         = CMD_PRE;
                            nxt_addr        = {req_bank, 1'b0, (ROW_W-1)'(0)};
                            pre_v[req_bank] = 1'b1;
                        end
                    end
                    BK_IDLE, BK_PRECH: begin
                        if (sel.closed_ok && rrd_q == '0) begin
                            nxt_cmd         = CMD_ACT;
                            nxt_addr        = {req_bank, req_row};
                            act_v[req_bank] = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            rrd_q  <= '0;
            ccd_q  <= '0;
        end else begin
            cmd_q  <= nxt_cmd;
            addr_q <= nxt_addr;
            if (nxt_cmd == CMD_ACT)  rrd_q <= RRD_W'(T_RRD - 1);
            else if (rrd_q != '0)    rrd_q <= rrd_q - 1'b1;
            if (nxt_cmd == CMD_READ) ccd_q <= CCD_W'(BL - 1);
            else if (ccd_q != '0)    ccd_q <= ccd_q - 1'b1;
        end
    end

    assign cmd_o  = cmd_q;
    assign addr_o = addr_q;

    sgram_rd_capture #(.CL(CL), .BL(BL), .DQ_W(DQ_W)) cap_i (
        .clk(clk), .rst(rst),
        .fire_i(cmd_q == CMD_READ),
        .dq_i(dq_i), .data_o(rd_data_o), .valid_o(rd_valid_o)
    );

endmodule

// File: rtl/sgram_bank_sched_chk.sv
module sgram_bank_sched_chk
    import sgram_sched_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int CL    = 3,
    parameter int BL    = 4,
    parameter int T_RRD = 2,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 6
) (
    input logic           clk,
    input logic           rst,
    input logic [1:0]     cmd_o,
    input logic [ROW_W:0] addr_o
);
    localparam int LOCK_LEN = CL + BL - 2 + T_RP;

    logic [7:0] since_any;
    logic [7:0] since_act [2];
    logic [7:0] since_pre [2];
    logic [7:0] lock_left [2];
    logic       bk, fl;

    assign bk = addr_o[ROW_W];
    assign fl = addr_o[ROW_W-1];

    function automatic logic [7:0] sat_inc(logic [7:0] c);
        return (c == 8'hFF) ? c : c + 8'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            since_any <= 8'hFF;
            for (int b = 0; b < 2; b++) begin
                since_act[b] <= 8'hFF;
                since_pre[b] <= 8'hFF;
                lock_left[b] <= 8'h00;
            end
        end else begin
            since_any <= (cmd_o == CMD_ACT) ? 8'd1 : sat_inc(since_any);
            for (int b = 0; b < 2; b++) begin
                since_act[b] <= (cmd_o == CMD_ACT && bk == 1'(b)) ? 8'd1 : sat_inc(since_act[b]);
                since_pre[b] <= (cmd_o == CMD_PRE && (fl || bk == 1'(b))) ? 8'd1 : sat_inc(since_pre[b]);
                if (cmd_o == CMD_READ && bk == 1'(b) && fl)
                    lock_left[b] <= 8'(LOCK_LEN - 1);
                else if (lock_left[b] != 8'h00)
                    lock_left[b] <= lock_left[b] - 8'd1;
            end
        end
    end

    AST_RRD_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT) |-> (since_any >= 8'(T_RRD)));                 // R3
    AST_RCD_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_READ) |-> (since_act[bk] >= 8'(T_RCD)));            // R4
    AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT) |-> (since_pre[bk] >= 8'(T_RP)));              // R6
    AST_RAS_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PRE && !fl) |-> (since_act[bk] >= 8'(T_RAS)));      // R7
    AST_AP_LOCK: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_NOP && !(cmd_o == CMD_PRE && fl)) |-> (lock_left[bk] == 8'h00)); // R8
    AST_PALL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PRE && fl) |-> (lock_left[0] == 8'h00 && lock_left[1] == 8'h00)); // R9

endmodule

bind sgram_bank_sched sgram_bank_sched_chk #(
    .ROW_W(ROW_W), .CL(CL), .BL(BL),
    .T_RRD(T_RRD), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
) chk_i (
    .clk(clk), .rst(rst), .cmd_o(cmd_o), .addr_o(addr_o)
);

// File: tb/sgram_bank_sched_tb_top.sv
module sgram_bank_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CL = 3, BL = 4, T_RRD = 2, T_RCD = 3, T_RP = 3, T_RAS = 6;
    localparam int RDP = CL + BL - 2;
    localparam int NVEC = 10;
    // {pall, bank, row[9:0], col[7:0], ap}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 10'd1, 8'd0,   1'b0},
        {1'b0, 1'b1, 10'd2, 8'd5,   1'b0},
        {1'b0, 1'b0, 10'd1, 8'd9,   1'b1},
        {1'b0, 1'b1, 10'd2, 8'd3,   1'b0},
        {1'b0, 1'b0, 10'd4, 8'd7,   1'b0},
        {1'b0, 1'b1, 10'd6, 8'd2,   1'b1},
        {1'b1, 1'b0, 10'd0, 8'd0,   1'b0},
        {1'b0, 1'b1, 10'd6, 8'd1,   1'b0},
        {1'b0, 1'b0, 10'd0, 8'd255, 1'b0},
        {1'b1, 1'b0, 10'd0, 8'd0,   1'b0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_pall = 1'b0, req_bank = 1'b0, req_ap = 1'b0;
    logic [9:0]  req_row = '0;
    logic [7:0]  req_col = '0;
    logic        req_ready;
    logic [1:0]  cmd_o;
    logic [10:0] addr_o;
    logic [31:0] dq = '0;
    logic [31:0] rd_data_o;
    logic        rd_valid_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgram_bank_sched #(.CL(CL), .BL(BL), .T_RRD(T_RRD), .T_RCD(T_RCD),
                       .T_RP(T_RP), .T_RAS(T_RAS)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pall(req_pall),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ap(req_ap),
        .req_ready(req_ready), .cmd_o(cmd_o), .addr_o(addr_o), .dq_i(dq),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int last_act_any = -1000, rd_cyc = -1000, prev_rd_cyc = -1000, rda_cyc = -1000;
    int pre_cyc = -1000, first_valid = -1000, run = 0, last_run = 0;
    int last_act [2] = '{-1000, -1000};
    int last_rd  [2] = '{-1000, -1000};
    int act_ok   [2] = '{-1000, -1000};
    int lock_til [2] = '{-1000, -1000};
    logic       open_b [2] = '{1'b0, 1'b0};
    logic [9:0] orow   [2];
    logic [10:0] act_addr, rd_addr;
    logic        pre_all = 1'b0, prev_v = 1'b0;
    logic [31:0] drv [64];
    logic [31:0] expq [512];
    int wr_p = 0, rd_p = 0;

    function automatic logic [31:0] word(logic b, logic [9:0] r, logic [7:0] c);
        return {13'h0A5, b, r, c};
    endfunction
    function automatic logic [7:0] bcol(logic [7:0] c, int k);
        return (c & ~8'(BL-1)) | ((c + 8'(k)) & 8'(BL-1));
    endfunction

    task automatic chk(string req, longint got, longint exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask
    task automatic chk_ge(string req, longint got, longint lo);
        n_chk++;
        if (got < lo) begin
            n_fail++;
            $display("FAIL %s: got %0d expected >= %0d", req, got, lo);
        end
    endtask

    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    initial for (int i = 0; i < 64; i++) drv[i] = '0;

    // bus monitor, SGRAM data model and output checker
    always @(negedge clk) begin
        if (!rst) begin
            automatic int n = cyc;
            automatic logic b = addr_o[10];
            automatic logic f = addr_o[9];
            case (cmd_o)
                2'd1: begin
                    chk_ge("R3 act-act gap", n - last_act_any, T_RRD);
                    chk_ge("R6/R8 act after precharge", n, act_ok[b]);
                    chk("R7 act on closed bank", open_b[b], 0);
                    last_act_any = n; last_act[b] = n; open_b[b] = 1'b1;
                    orow[b] = addr_o[9:0]; act_addr = addr_o;
                end
                2'd2: begin
                    chk("R4 read on open bank", open_b[b], 1);
                    chk_ge("R4 act-read gap", n - last_act[b], T_RCD);
                    chk_ge("R8 read lockout", n, lock_til[b]);
                    for (int k = 0; k < BL; k++)
                        drv[(n + CL + k) % 64] = word(b, orow[b], bcol(addr_o[7:0], k));
                    prev_rd_cyc = rd_cyc; rd_cyc = n; last_rd[b] = n; rd_addr = addr_o;
                    if (f) begin
                        automatic int st = n + RDP;
                        if (last_act[b] + T_RAS > st) st = last_act[b] + T_RAS;
                        act_ok[b] = st + T_RP; lock_til[b] = st + T_RP;
                        open_b[b] = 1'b0; rda_cyc = n;
                    end
                end
                2'd3: begin
                    for (int j = 0; j < 2; j++) begin
                        if (f || b == 1'(j)) begin
                            chk_ge("R8/R9 precharge lockout", n, lock_til[j]);
                            if (open_b[j]) begin
                                chk_ge("R7 act-pre gap", n - last_act[j], T_RAS);
                                chk_ge("R7 read-pre gap", n - last_rd[j], RDP);
                            end
                            act_ok[j] = n + T_RP; open_b[j] = 1'b0;
                        end
                    end
                    pre_cyc = n; pre_all = f;
                end
                default: ;
            endcase
            dq = drv[n % 64];
            drv[n % 64] = '0;
            if (rd_valid_o) begin
                if (!prev_v) first_valid = n;
                run++;
                chk("R5 burst word", rd_data_o, (rd_p < wr_p) ? expq[rd_p] : 32'hDEAD_BEEF);
                rd_p++;
            end else if (run != 0) begin
                last_run = run; run = 0;
            end
            prev_v = rd_valid_o;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic pall, logic b, logic [9:0] r, logic [7:0] c, logic ap);
        @(negedge clk);
        req_valid = 1'b1; req_pall = pall; req_bank = b; req_row = r; req_col = c; req_ap = ap;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        if (!pall)
            for (int k = 0; k < BL; k++) begin
                expq[wr_p] = word(b, r, bcol(c, k)); wr_p++;
            end
        @(posedge clk); #1;
        chk("R11 final command after ready", cmd_o, pall ? 2 'd3 : 2'd2);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset cmd", cmd_o, 0);
        chk("R1 reset valid", rd_valid_o, 0);
        chk("R1 reset ready", req_ready, 0);
        @(negedge clk); rst = 1'b0;

        for (int v = 0; v < NVEC; v++)
            send(VEC[v][20], VEC[v][19], VEC[v][18:9], VEC[v][8:1], VEC[v][0]);
        idle(20);

        // cold read: ACT, READ after T_RCD, data after CL
        send(1'b0, 1'b0, 10'd5, 8'd2, 1'b0);
        idle(20);
        chk("R2 act row field", act_addr[9:0], 5);
        chk("R2 read column field", rd_addr[7:0], 2);
        chk("R4 read exactly T_RCD after act", rd_cyc - last_act[0], T_RCD);
        chk("R5 first word latency", first_valid - rd_cyc, CL + 1);
        chk("R5 valid words per burst", last_run, BL);

        // interleave across the two banks
        send(1'b0, 1'b1, 10'd7, 8'd0, 1'b0);
        idle(20);
        send(1'b0, 1'b0, 10'd5, 8'd4, 1'b0);
        send(1'b0, 1'b1, 10'd7, 8'd8, 1'b0);
        idle(20);
        chk("R10 read spacing", rd_cyc - prev_rd_cyc, BL);
        chk("R10 continuous valid run", last_run, 2 * BL);

        // auto-precharge lockout then reopen
        send(1'b0, 1'b0, 10'd5, 8'd0, 1'b1);
        send(1'b0, 1'b0, 10'd5, 8'd1, 1'b0);
        idle(30);
        chk("R8 act after auto-precharge", last_act[0] - rda_cyc, RDP + T_RP);

        // row miss on bank 1
        send(1'b0, 1'b1, 10'd9, 8'd6, 1'b0);
        idle(20);
        chk("R6 pre-act gap on row miss", last_act[1] - pre_cyc, T_RP);
        chk("R7 read after reopen", rd_cyc - last_act[1], T_RCD);

        // precharge both banks
        send(1'b1, 1'b0, 10'd0, 8'd0, 1'b0);
        idle(2);
        chk("R9 all-bank flag", pre_all, 1);
        send(1'b0, 1'b1, 10'd3, 8'd1, 1'b0);
        idle(20);
        chk("R9 act after all-bank precharge", last_act[1] - pre_cyc, T_RP);
        chk("R5 all words delivered", rd_p, wr_p);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule